// File: doc/BRIEF.md
# TDM Four-Octet Frame Transceiver

This block moves a 32-bit time-division frame in each direction over a serial port with one data line per direction, as used between an ISDN line-interface device and a layer-2 controller. A data clock and a frame-sync strobe arrive as inputs. The data clock runs at twice the bit rate, so every serial bit occupies two data-clock periods. Each frame carries four octets: two 8-bit bearer channels, a monitor octet, and a control octet. The control octet packs a 2-bit D-channel field, a 4-bit command/indication field, a spare bit and a monitor-valid bit.

The block runs on a fast system clock and observes the data clock and frame sync as levels that are already synchronous to it. It detects the edges of the data clock itself. Transmit fields are captured when a frame starts and shifted out MSB first. Received bits are collected during the frame. At the end of the frame the decoded fields are presented together with a one-cycle completion strobe. A stop/go flag is taken from a fixed bit of the received monitor octet. A sync that arrives away from the expected frame boundary, or that fails to arrive there, raises a one-cycle framing-error pulse. The counters then realign, or carry on counting if no sync came.

Top module: `tdm_frame_xcvr`

## Requirements
- R1: While reset is asserted and until the first frame sync, `txd` is 1, `rx_done` and `frame_err` are 0, and every received field output is 0.
- R2: Until a frame sync has been seen on a rising data-clock edge, data-clock activity produces no `rx_done`, no `frame_err`, and `txd` stays 1.
- R3: The transmit frame is the 32-bit word {B1[7:0], B2[7:0], MON[7:0], D[1:0], CI[3:0], T, E}, with word bit 31 sent first. Its first bit starts on the rising data-clock edge where `fsync` is 1, and each bit is held for two data-clock periods.
- R4: The T position of the transmit word (word bit 1) is always sent as 1.
- R5: Each received bit is sampled on the falling data-clock edge inside the second period of that bit. The received word is decoded with the R3 layout into `rx_b1`, `rx_b2`, `rx_mon`, `rx_d`, `rx_ci` and `rx_e`.
- R6: `rx_stopgo` equals bit 3 of the received monitor octet (received word bit 11).
- R7: `rx_done` is a single-cycle pulse, issued once per complete frame right after the 32nd bit is sampled. The received fields change only together with it.
- R8: Transmit field inputs are captured at frame start. A change during a frame takes effect only in the next frame.
- R9: A sync seen before the 64th data-clock period of a frame restarts the frame at that edge and pulses `frame_err`. The cut-short frame produces no `rx_done`.
- R10: If no sync is present at the rising edge after the 64th period, the frame count wraps by itself, `frame_err` pulses, and transmit and receive carry on with that alignment. A later sync that falls on that boundary causes no error.
- R11: The received T bit (word bit 1) has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk | input | 1 | Data clock level, twice the bit rate |
| fsync | input | 1 | Frame sync level |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| tx_b1 | input | 8 | First bearer octet to send |
| tx_b2 | input | 8 | Second bearer octet to send |
| tx_mon | input | 8 | Monitor octet to send |
| tx_d | input | 2 | D-channel bits to send |
| tx_ci | input | 4 | Command/indication bits to send |
| tx_e | input | 1 | Monitor-valid bit to send |
| rx_b1 | output | 8 | Received first bearer octet |
| rx_b2 | output | 8 | Received second bearer octet |
| rx_mon | output | 8 | Received monitor octet |
| rx_d | output | 2 | Received D-channel bits |
| rx_ci | output | 4 | Received command/indication bits |
| rx_e | output | 1 | Received monitor-valid bit |
| rx_stopgo | output | 1 | Stop/go flag from received monitor bit 3 |
| rx_done | output | 1 | One-cycle received-frame strobe |
| frame_err | output | 1 | One-cycle framing-error pulse |

## Verification
The bench targets the frame edges. An early sync cuts a frame short; a design that still counted the remnant would emit a spurious `rx_done` or fail to flag the error. A missing sync must be bridged by flywheel counting; a design that stalled instead of wrapping would lose the next frame and also flag the properly placed sync that follows. The bench changes the transmit fields mid-frame, which exposes a design that shifts from live inputs rather than a captured copy. It flips only the received T bit and pushes opposite values through monitor bit 3, which catch an off-by-one field slice or a sample taken in the wrong half of a bit.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int OCT_W      = 8;
  localparam int OCTETS     = 4;
  localparam int FRAME_BITS = OCT_W * OCTETS;
  localparam int D_W        = 2;
  localparam int CI_W       = 4;
  localparam int STOPGO_BIT = 3;

  // control octet, first-sent field at the top
  typedef struct packed {
    logic [D_W-1:0]  d;
    logic [CI_W-1:0] ci;
    logic            t;
    logic            e;
  } ctrl_oct_t;
endpackage

// File: rtl/tdm_timebase.sv
module tdm_timebase
  import tdm_pkg::*;
#(
  parameter int CLKS_PER_BIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dclk,
  input  logic fsync,
  output logic frame_start,
  output logic bit_shift,
  output logic rx_samp,
  output logic rx_last,
  output logic frame_err
);
  localparam int FRAME_CLKS = FRAME_BITS * CLKS_PER_BIT;
  localparam int CNT_W      = $clog2(FRAME_CLKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_CLKS - 1);
  localparam logic [CNT_W-1:0] SUB_MASK = CNT_W'(CLKS_PER_BIT - 1);

  logic             dclk_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lock_q, lock_d;
  logic             start_q, start_d;
  logic             shift_q, shift_d;
  logic             err_q, err_d;
  logic             rise, fall;

  assign rise = dclk & ~dclk_q;
  assign fall = ~dclk & dclk_q;

  always_comb begin
    cnt_d   = cnt_q;
    lock_d  = lock_q;
    start_d = 1'b0;
    shift_d = 1'b0;
    err_d   = 1'b0;
    if (rise) begin
      if (fsync) begin
        cnt_d   = '0;
        lock_d  = 1'b1;
        start_d = 1'b1;
        err_d   = lock_q && (cnt_q != CNT_LAST);
      end else if (lock_q) begin
        if (cnt_q == CNT_LAST) begin
          cnt_d   = '0;
          start_d = 1'b1;
          err_d   = 1'b1;
        end else begin
          cnt_d   = cnt_q + CNT_W'(1);
          shift_d = ((cnt_d & SUB_MASK) == '0);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q  <= 1'b0;
      cnt_q   <= '0;
      lock_q  <= 1'b0;
      start_q <= 1'b0;
      shift_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      dclk_q  <= dclk;
      start_q <= start_d;
      shift_q <= shift_d;
      err_q   <= err_d;
      if (rise) begin
        cnt_q  <= cnt_d;
        lock_q <= lock_d;
      end
    end
  end

  assign frame_start = start_q;
  assign bit_shift   = shift_q;
  assign frame_err   = err_q;
  assign rx_samp     = fall && lock_q && ((cnt_q & SUB_MASK) == SUB_MASK);
  assign rx_last     = (cnt_q == CNT_LAST);

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(cnt_q));

  // R10
  start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (cnt_q == '0));
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser
  import tdm_pkg::*;
#(
  parameter logic T_IDLE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            shift,
  input  logic [OCT_W-1:0] b1,
  input  logic [OCT_W-1:0] b2,
  input  logic [OCT_W-1:0] mon,
  input  logic [D_W-1:0]  d,
  input  logic [CI_W-1:0] ci,
  input  logic            e,
  output logic            txd
);
  logic [FRAME_BITS-1:0] sreg_q, sreg_d;
  logic                  live_q, live_d;
  ctrl_oct_t             ctrl;

  always_comb begin
    ctrl.d  = d;
    ctrl.ci = ci;
    ctrl.t  = T_IDLE;
    ctrl.e  = e;
  end

  always_comb begin
    sreg_d = sreg_q;
    live_d = live_q;
    if (load) begin
      sreg_d = {b1, b2, mon, ctrl};
      live_d = 1'b1;
    end else if (shift) begin
      sreg_d = {sreg_q[FRAME_BITS-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '1;
      live_q <= 1'b0;
    end else if (load || shift) begin
      sreg_q <= sreg_d;
      live_q <= live_d;
    end
  end

  assign txd = live_q ? sreg_q[FRAME_BITS-1] : 1'b1;

  // R3
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (txd == $past(b1[OCT_W-1])));

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(txd));
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
  import tdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp,
  input  logic             last,
  input  logic             rxd,
  output logic [OCT_W-1:0] b1,
  output logic [OCT_W-1:0] b2,
  output logic [OCT_W-1:0] mon,
  output logic [D_W-1:0]   d,
  output logic [CI_W-1:0]  ci,
  output logic             e,
  output logic             stopgo,
  output logic             done
);
  // shift register holds the first 31 bits; the 32nd arrives on rxd
  localparam int SR_W   = FRAME_BITS - 1;
  localparam int OFF_CI = 1;
  localparam int OFF_D  = OFF_CI + CI_W;
  localparam int OFF_MN = OFF_D + D_W;
  localparam int OFF_B2 = OFF_MN + OCT_W;
  localparam int OFF_B1 = OFF_B2 + OCT_W;

  logic [SR_W-1:0] sreg_q, sreg_d;
  logic            done_q, done_d;
  logic            grab;

  assign grab   = samp && last;
  assign sreg_d = {sreg_q[SR_W-2:0], rxd};
  assign done_d = grab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else if (samp) begin
      sreg_q <= sreg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b1     <= '0;
      b2     <= '0;
      mon    <= '0;
      d      <= '0;
      ci     <= '0;
      e      <= 1'b0;
      stopgo <= 1'b0;
    end else if (grab) begin
      b1     <= sreg_q[OFF_B1 +: OCT_W];
      b2     <= sreg_q[OFF_B2 +: OCT_W];
      mon    <= sreg_q[OFF_MN +: OCT_W];
      d      <= sreg_q[OFF_D +: D_W];
      ci     <= sreg_q[OFF_CI +: CI_W];
      e      <= rxd;
      stopgo <= sreg_q[OFF_MN + STOPGO_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign done = done_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/tdm_frame_xcvr.sv
module tdm_frame_xcvr
  import tdm_pkg::*;
#(
  parameter int   CLKS_PER_BIT = 2,
  parameter logic T_IDLE       = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dclk,
  input  logic             fsync,
  input  logic             rxd,
  output logic             txd,
  input  logic [OCT_W-1:0] tx_b1,
  input  logic [OCT_W-1:0] tx_b2,
  input  logic [OCT_W-1:0] tx_mon,
  input  logic [D_W-1:0]   tx_d,
  input  logic [CI_W-1:0]  tx_ci,
  input  logic             tx_e,
  output logic [OCT_W-1:0] rx_b1,
  output logic [OCT_W-1:0] rx_b2,
  output logic [OCT_W-1:0] rx_mon,
  output logic [D_W-1:0]   rx_d,
  output logic [CI_W-1:0]  rx_ci,
  output logic             rx_e,
  output logic             rx_stopgo,
  output logic             rx_done,
  output logic             frame_err
);
  logic frame_start, bit_shift, rx_samp, rx_last;

  tdm_timebase #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tb (
    .clk         (clk),
    .rst_n       (rst_n),
    .dclk        (dclk),
    .fsync       (fsync),
    .frame_start (frame_start),
    .bit_shift   (bit_shift),
    .rx_samp     (rx_samp),
    .rx_last     (rx_last),
    .frame_err   (frame_err)
  );

  tdm_tx_ser #(.T_IDLE(T_IDLE)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (frame_start),
    .shift (bit_shift),
    .b1    (tx_b1),
    .b2    (tx_b2),
    .mon   (tx_mon),
    .d     (tx_d),
    .ci    (tx_ci),
    .e     (tx_e),
    .txd   (txd)
  );

  tdm_rx_deser u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .samp   (rx_samp),
    .last   (rx_last),
    .rxd    (rxd),
    .b1     (rx_b1),
    .b2     (rx_b2),
    .mon    (rx_mon),
    .d      (rx_d),
    .ci     (rx_ci),
    .e      (rx_e),
    .stopgo (rx_stopgo),
    .done   (rx_done)
  );
endmodule

// File: tb/tdm_frame_xcvr_test.sv
module tdm_frame_xcvr_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, dclk, fsync, rxd, txd;
  logic [31:0] tx_cfg, alt_cfg;
  logic [7:0]  rx_b1, rx_b2, rx_mon;
  logic [1:0]  rx_d;
  logic [3:0]  rx_ci;
  logic        rx_e, rx_stopgo, rx_done, frame_err;

  tdm_frame_xcvr uut (
    .clk(clk), .rst_n(rst_n), .dclk(dclk), .fsync(fsync), .rxd(rxd), .txd(txd),
    .tx_b1(tx_cfg[31:24]), .tx_b2(tx_cfg[23:16]), .tx_mon(tx_cfg[15:8]),
    .tx_d(tx_cfg[7:6]), .tx_ci(tx_cfg[5:2]), .tx_e(tx_cfg[0]),
    .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_mon(rx_mon), .rx_d(rx_d), .rx_ci(rx_ci),
    .rx_e(rx_e), .rx_stopgo(rx_stopgo), .rx_done(rx_done), .frame_err(frame_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;
  int err_cnt = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (rx_done)   done_cnt = done_cnt + 1;
      if (frame_err) err_cnt  = err_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tx_word(input logic [31:0] c);
    return {c[31:2], 1'b1, c[0]};
  endfunction

  // one data-clock period: high for 4 system clocks, then low for 4
  task automatic dperiod(input bit sync, input bit rbit, output bit txb);
    dclk  = 1'b1;
    fsync = sync;
    rxd   = rbit;
    repeat (4) @(negedge clk);
    txb   = txd;
    dclk  = 1'b0;
    fsync = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_frame(input bit sync, input logic [31:0] rw, input int nper,
                           input int chg_at, output logic [31:0] tw);
    bit tb;
    tw = '1;
    for (int p = 0; p < nper; p++) begin
      if (p == chg_at) tx_cfg = alt_cfg;
      dperiod(sync && (p == 0), rw[31 - p/2], tb);
      if (p % 2 == 1) tw[31 - p/2] = tb;
    end
  endtask

  task automatic check_rx(input string tag, input logic [31:0] rw);
    check({tag, " R5 b1"},  {24'd0, rx_b1},  {24'd0, rw[31:24]});
    check({tag, " R5 b2"},  {24'd0, rx_b2},  {24'd0, rw[23:16]});
    check({tag, " R5 mon"}, {24'd0, rx_mon}, {24'd0, rw[15:8]});
    check({tag, " R5 ctrl"}, {26'd0, rx_d, rx_ci}, {26'd0, rw[7:2]});
    check({tag, " R5 e"},   {31'd0, rx_e},   {31'd0, rw[0]});
    check({tag, " R6 stopgo"}, {31'd0, rx_stopgo}, {31'd0, rw[11]});
  endtask

  task automatic t_reset();
    check("R1 txd", {31'd0, txd}, 32'd1);
    check("R1 done/err", {30'd0, rx_done, frame_err}, 32'd0);
    check("R1 fields", {rx_b1, rx_b2, rx_mon, rx_d, rx_ci, rx_e, rx_stopgo}, 32'd0);
  endtask

  task automatic t_presync();
    logic [31:0] tw;
    tx_cfg = 32'h1234_5678;
    run_frame(1'b0, 32'h5A5A_5A5A, 64, -1, tw);
    check("R2 txd idle", tw, 32'hFFFF_FFFF);
    check("R2 no done", done_cnt, 0);
    check("R2 no err", err_cnt, 0);
  endtask

  task automatic t_basic();
    logic [31:0] tw, rw;
    int d0, e0;
    d0 = done_cnt; e0 = err_cnt;
    tx_cfg = 32'hA53C_0F94;
    rw     = 32'hC3_81_08_B5;
    run_frame(1'b1, rw, 64, -1, tw);
    check("R3 tx word", tw, tx_word(32'hA53C_0F94));
    check("R4 T idle", {31'd0, tw[1]}, 32'd1);
    check("R7 one done", done_cnt - d0, 1);
    check("R10 no err", err_cnt - e0, 0);
    check_rx("basic", rw);
  endtask

  task automatic t_second();
    logic [31:0] tw, rw;
    logic [7:0] s_b1, s_b2, s_mon;
    logic [6:0] s_ctl;
    rw = 32'h3C_7E_F7_4A;
    tx_cfg = 32'h0180_FF01;
    run_frame(1'b1, rw, 64, -1, tw);
    check("R3 tx word 2", tw, tx_word(32'h0180_FF01));
    check_rx("second", rw);
    s_b1 = rx_b1; s_b2 = rx_b2; s_mon = rx_mon;
    s_ctl = {rx_d, rx_ci, rx_e};
    // R11: same word with only the T bit flipped
    run_frame(1'b1, rw ^ 32'h2, 64, -1, tw);
    check("R11 T ignored", {rx_b1, rx_b2, rx_mon, 1'b0, s_ctl},
                           {s_b1, s_b2, s_mon, 1'b0, rx_d, rx_ci, rx_e});
    check("R11 T ignored vs word", {25'd0, rx_d, rx_ci, rx_e}, {25'd0, rw[7:2], rw[0]});
  endtask

  task automatic t_hold();
    logic [31:0] tw;
    tx_cfg  = 32'hF00F_6699;
    alt_cfg = 32'h0FF0_9966;
    run_frame(1'b1, 32'h0, 64, 10, tw);
    check("R8 captured at start", tw, tx_word(32'hF00F_6699));
    run_frame(1'b1, 32'h0, 64, -1, tw);
    check("R8 next frame", tw, tx_word(32'h0FF0_9966));
  endtask

  task automatic t_early();
    logic [31:0] tw, rw;
    int d0, e0;
    d0 = done_cnt; e0 = err_cnt;
    run_frame(1'b1, 32'hFFFF_FFFF, 20, -1, tw);
    check("R9 partial no done", done_cnt - d0, 0);
    rw = 32'h6D_12_F0_2E;
    tx_cfg = 32'h8421_1248;
    run_frame(1'b1, rw, 64, -1, tw);
    check("R9 err pulse", err_cnt - e0, 1);
    check("R9 one done", done_cnt - d0, 1);
    check("R9 realigned tx", tw, tx_word(32'h8421_1248));
    check_rx("R9 realigned", rw);
  endtask

  task automatic t_flywheel();
    logic [31:0] tw, rw;
    int d0, e0;
    run_frame(1'b1, 32'h1111_1111, 64, -1, tw);
    d0 = done_cnt; e0 = err_cnt;
    rw = 32'h9E_64_00_D3;
    tx_cfg = 32'hCAFE_0155;
    run_frame(1'b0, rw, 64, -1, tw);
    check("R10 missing sync err", err_cnt - e0, 1);
    check("R10 flywheel done", done_cnt - d0, 1);
    check("R10 flywheel tx", tw, tx_word(32'hCAFE_0155));
    check_rx("R10 flywheel", rw);
    e0 = err_cnt;
    run_frame(1'b1, 32'h0, 64, -1, tw);
    check("R10 aligned sync no err", err_cnt - e0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dclk = 1'b0; fsync = 1'b0; rxd = 1'b1;
    tx_cfg = '0; alt_cfg = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_presync();
    t_basic();
    t_second();
    t_hold();
    t_early();
    t_flywheel();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule